// File: doc/BRIEF.md
# Wake Event Signal Controller

This block turns an internal power-management event into the signals that leave the device. The first is an active-low, open-drain event request, modelled as an output enable that pulls the line low while set and releases it otherwise. The second is a LAN wake-up line to the motherboard. A 2-bit style setting selects the wake line's polarity and whether it is a level or a fixed-length pulse. An event stays pending until software clears it with a status-clear strobe or a bus reset.

A gating option makes the wake line depend on the isolate input. With gating on, the wake line is active only while the event request is set and the device is isolated. The isolate input is active low and passes through a two-flip-flop synchroniser. While isolated, the block drops the enable for its bus-side drivers, but the event request keeps working. During isolation the bus-side inputs, the clear strobe and the bus reset, are ignored. All outputs are registered. An always-on auxiliary reset initialises the block.

Top module: `wake_event_ctrl`

## Requirements
- R1: While `aux_rst_n` is low, `pme_oe`, `wake_out` and `bus_drv_en` are all 0. The block also comes out of reset in the isolated state.
- R2: When `pwr_evt` is high at a clock edge, `pme_oe` is 1 after that edge. It stays 1 until a clear that takes effect.
- R3: `wake_style` encodes 00 active-high level, 01 active-low level, 10 positive pulse and 11 negative pulse. When not asserted, `wake_out` sits at `wake_style[0]`.
- R4: In the level styles with `gate_en`=0, `wake_out` is asserted on the same edge that sets `pme_oe`. It stays asserted for as long as `pme_oe` is held.
- R5: In the pulse styles, each new event asserts `wake_out` for exactly PULSE_LEN cycles, starting on the edge that sets `pme_oe`. A further event during the pulse does not restart it.
- R6: With `gate_en`=1, `wake_out` is asserted only while `pme_oe` is set and the synchronised isolate is active. A change on `iso_n` reaches the output on the third clock edge.
- R7: While isolated, `bus_drv_en` is 0, and `evt_clr` and `bus_rst_n` have no effect on `pme_oe`. `pwr_evt` still sets `pme_oe`. When not isolated, `bus_drv_en` is 1.
- R8: When not isolated, `evt_clr` high or `bus_rst_n` low at an edge releases `pme_oe` after that edge.
- R9: A change of `wake_style` or `gate_en` shows on `wake_out` after one clock edge.
- R10: If `pwr_evt` and a clear arrive at the same edge, the event wins and `pme_oe` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aux_rst_n | input | 1 | Always-on asynchronous reset, active low |
| pwr_evt | input | 1 | Internal power-management event strobe |
| evt_clr | input | 1 | Status-clear strobe from the bus side |
| bus_rst_n | input | 1 | Bus reset, active low, ignored while isolated |
| iso_n | input | 1 | Isolate request, active low, asynchronous |
| wake_style | input | 2 | Wake line style select |
| gate_en | input | 1 | Tie the wake line to the event request and isolate |
| pme_oe | output | 1 | Event request pull-down enable (1 = line pulled low) |
| wake_out | output | 1 | LAN wake-up line |
| bus_drv_en | output | 1 | Enable for the bus-side output drivers |

## Verification
Event, clear, style and gating inputs act through one register stage, so their effect is due one edge after they are driven. Changes on `iso_n` pass two synchroniser stages and one output register, so they are due on the third edge. The bench drives every input just after a falling edge and samples on the next falling edge. For isolate changes it checks both that the output has not moved after two edges and that it has moved after three. Pulse widths are measured by counting asserted samples edge by edge against PULSE_LEN.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;

  typedef enum logic [1:0] {
    WK_LVL_HI  = 2'b00,
    WK_LVL_LO  = 2'b01,
    WK_PLS_POS = 2'b10,
    WK_PLS_NEG = 2'b11
  } wake_style_e;

  // Pin level for a given style and logical assertion.
  function automatic logic wake_pin_level(input logic [1:0] style, input logic active);
    return active ^ style[0];
  endfunction

  function automatic logic style_is_pulse(input logic [1:0] style);
    return style[1];
  endfunction

  // Next pending state: a new event beats any clear.
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/wake_iso_sync.sv
module wake_iso_sync (
  input  logic clk,
  input  logic aux_rst_n,
  input  logic iso_n,
  output logic iso_act
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) sync_q <= 2'b00;
    else            sync_q <= {sync_q[0], iso_n};
  end

  assign iso_act = ~sync_q[1];
endmodule

// File: rtl/wake_evt_latch.sv
module wake_evt_latch
  import wake_evt_pkg::*;
(
  input  logic clk,
  input  logic aux_rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_nxt,
  output logic pend_q
);
  assign pend_nxt = pend_next(pend_q, set_i, clr_i);

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) pend_q <= 1'b0;
    else            pend_q <= pend_nxt;
  end
endmodule

// File: rtl/wake_pulse_gen.sv
module wake_pulse_gen #(
  parameter int PULSE_LEN = 16,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk,
  input  logic             aux_rst_n,
  input  logic             start_i,
  output logic             act_nxt,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] LEN_V = CNT_W'(PULSE_LEN);
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (cnt_q != '0)   cnt_nxt = cnt_q - 1'b1;
    else if (start_i)  cnt_nxt = LEN_V;
    else               cnt_nxt = '0;
  end

  assign act_nxt = (cnt_nxt != '0);

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) cnt_q <= '0;
    else            cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_evt_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic       clk,
  input  logic       aux_rst_n,
  input  logic       pwr_evt,
  input  logic       evt_clr,
  input  logic       bus_rst_n,
  input  logic       iso_n,
  input  logic [1:0] wake_style,
  input  logic       gate_en,
  output logic       pme_oe,
  output logic       wake_out,
  output logic       bus_drv_en
);
  // Named internal events, visible to the bound checker.
  logic             iso_act;
  logic             clr_eff;
  logic             pend_nxt;
  logic             pend_q;
  logic             qual_nxt;
  logic             qual_q;
  logic             pulse_start;
  logic             pulse_act_nxt;
  logic [CNT_W-1:0] pulse_cnt;
  logic             wake_active_nxt;

  wake_iso_sync u_sync (
    .clk       (clk),
    .aux_rst_n (aux_rst_n),
    .iso_n     (iso_n),
    .iso_act   (iso_act)
  );

  // Bus-side clears are honoured only while not isolated.
  assign clr_eff = ~iso_act & (evt_clr | ~bus_rst_n);

  wake_evt_latch u_latch (
    .clk       (clk),
    .aux_rst_n (aux_rst_n),
    .set_i     (pwr_evt),
    .clr_i     (clr_eff),
    .pend_nxt  (pend_nxt),
    .pend_q    (pend_q)
  );

  assign qual_nxt    = pend_nxt & (~gate_en | iso_act);
  assign pulse_start = qual_nxt & ~qual_q;

  wake_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk       (clk),
    .aux_rst_n (aux_rst_n),
    .start_i   (pulse_start),
    .act_nxt   (pulse_act_nxt),
    .cnt_q     (pulse_cnt)
  );

  assign wake_active_nxt = style_is_pulse(wake_style) ? (pulse_act_nxt & qual_nxt) : qual_nxt;

  always_ff @(posedge clk or negedge aux_rst_n) begin
    if (!aux_rst_n) begin
      qual_q     <= 1'b0;
      wake_out   <= 1'b0;
      bus_drv_en <= 1'b0;
    end else begin
      qual_q     <= qual_nxt;
      wake_out   <= wake_pin_level(wake_style, wake_active_nxt);
      bus_drv_en <= ~iso_act;
    end
  end

  assign pme_oe = pend_q;
endmodule

// File: rtl/wake_event_ctrl_chk.sv
module wake_event_ctrl_chk #(
  parameter int PULSE_LEN = 16,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input logic             clk,
  input logic             aux_rst_n,
  input logic             pwr_evt,
  input logic             evt_clr,
  input logic             bus_rst_n,
  input logic [1:0]       wake_style,
  input logic             gate_en,
  input logic             iso_act,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             pme_oe,
  input logic             wake_out,
  input logic             bus_drv_en
);
  // R2
  pme_set_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    pwr_evt |=> pme_oe);
  // R2
  pme_hold_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (pme_oe && !evt_clr && bus_rst_n) |=> pme_oe);
  // R7
  iso_mask_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    iso_act |=> !bus_drv_en);
  // R7
  iso_clr_ignore_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (iso_act && pme_oe) |=> pme_oe);
  // R4
  lvl_hi_follow_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (!gate_en && wake_style == 2'b00) |=> (wake_out == pme_oe));
  // R4
  lvl_lo_follow_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (!gate_en && wake_style == 2'b01) |=> (wake_out == !pme_oe));
  // R6
  gate_block_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (gate_en && !iso_act) |=> (wake_out == $past(wake_style[0])));
  // R5
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    pulse_cnt <= CNT_W'(PULSE_LEN));
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!aux_rst_n)
    (!pme_oe && !pwr_evt) |=> (wake_out == $past(wake_style[0])));
endmodule

bind wake_event_ctrl wake_event_ctrl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk        (clk),
  .aux_rst_n  (aux_rst_n),
  .pwr_evt    (pwr_evt),
  .evt_clr    (evt_clr),
  .bus_rst_n  (bus_rst_n),
  .wake_style (wake_style),
  .gate_en    (gate_en),
  .iso_act    (iso_act),
  .pulse_cnt  (pulse_cnt),
  .pme_oe     (pme_oe),
  .wake_out   (wake_out),
  .bus_drv_en (bus_drv_en)
);

// File: tb/wake_event_ctrl_bench.sv
`timescale 1ns/1ps
module wake_event_ctrl_bench;
  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       aux_rst_n = 1'b0;
  logic       pwr_evt = 1'b0;
  logic       evt_clr = 1'b0;
  logic       bus_rst_n = 1'b1;
  logic       iso_n = 1'b1;
  logic [1:0] wake_style = 2'b00;
  logic       gate_en = 1'b0;
  logic       pme_oe, wake_out, bus_drv_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wake_event_ctrl #(.PULSE_LEN(PL)) u_wake_event_ctrl (
    .clk(clk), .aux_rst_n(aux_rst_n), .pwr_evt(pwr_evt), .evt_clr(evt_clr),
    .bus_rst_n(bus_rst_n), .iso_n(iso_n), .wake_style(wake_style), .gate_en(gate_en),
    .pme_oe(pme_oe), .wake_out(wake_out), .bus_drv_en(bus_drv_en)
  );

  // Expected pin level: asserted flips with style bit 0.
  function automatic logic pin(input logic [1:0] st, input logic act);
    return st[0] ? ~act : act;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic evt_pulse();
    pwr_evt = 1'b1; step(); pwr_evt = 1'b0;
  endtask

  task automatic clr_pulse();
    evt_clr = 1'b1; step(); evt_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n_act;
    step(); step();
    chk("R1 pme_oe", pme_oe, 1'b0);
    chk("R1 wake_out", wake_out, 1'b0);
    chk("R1 bus_drv_en", bus_drv_en, 1'b0);
    aux_rst_n = 1'b1;
    step(); step();
    chk("R1 isolated until sync", bus_drv_en, 1'b0);
    step();
    chk("R7 drivers on when not isolated", bus_drv_en, 1'b1);

    // Sweep all styles, ungated.
    for (int s = 0; s < 4; s++) begin
      wake_style = 2'(s); step();
      chk("R3 idle level", wake_out, pin(2'(s), 1'b0));
      evt_pulse();
      chk("R2 pme set", pme_oe, 1'b1);
      n_act = (wake_out == pin(2'(s), 1'b1)) ? 1 : 0;
      chk("R4/R5 same edge", wake_out, pin(2'(s), 1'b1));
      for (int k = 1; k < PL + 3; k++) begin
        if (k == 1) pwr_evt = 1'b1;
        step(); pwr_evt = 1'b0;
        if (wake_out == pin(2'(s), 1'b1)) n_act++;
        chk("R2 pme held", pme_oe, 1'b1);
      end
      if (s >= 2) begin
        checks++;
        if (n_act != PL) begin
          fails++;
          $display("FAIL R5 pulse width: got %0d expected %0d", n_act, PL);
        end
      end else begin
        chk("R4 level held", wake_out, pin(2'(s), 1'b1));
      end
      clr_pulse();
      chk("R8 clear releases", pme_oe, 1'b0);
      chk("R3 back to idle", wake_out, pin(2'(s), 1'b0));
    end

    // R9: style and gate changes while pending.
    wake_style = 2'b00; evt_pulse();
    chk("R4 active-high", wake_out, 1'b1);
    wake_style = 2'b01; step();
    chk("R9 style change", wake_out, 1'b0);
    gate_en = 1'b1; step();
    chk("R9 gate change", wake_out, 1'b1);
    wake_style = 2'b00; step();
    chk("R6 gated not isolated", wake_out, 1'b0);

    // R6/R7: isolate with gating.
    iso_n = 1'b0; step(); step();
    chk("R6 not yet after two edges", wake_out, 1'b0);
    chk("R7 drivers not yet off", bus_drv_en, 1'b1);
    step();
    chk("R6 gated wake on isolate", wake_out, 1'b1);
    chk("R7 drivers off", bus_drv_en, 1'b0);
    clr_pulse();
    chk("R7 clear ignored", pme_oe, 1'b1);
    bus_rst_n = 1'b0; step(); bus_rst_n = 1'b1;
    chk("R7 bus reset ignored", pme_oe, 1'b1);
    chk("R6 wake stays", wake_out, 1'b1);
    iso_n = 1'b1; step(); step(); step();
    chk("R6 gated off after release", wake_out, 1'b0);
    chk("R7 drivers back", bus_drv_en, 1'b1);
    bus_rst_n = 1'b0; step(); bus_rst_n = 1'b1;
    chk("R8 bus reset clears", pme_oe, 1'b0);

    // Gated pulse while isolated.
    wake_style = 2'b11; iso_n = 1'b0; step(); step(); step();
    evt_pulse();
    chk("R7 event while isolated", pme_oe, 1'b1);
    n_act = (wake_out == 1'b0) ? 1 : 0;
    for (int k = 1; k < PL + 2; k++) begin
      step();
      if (wake_out == 1'b0) n_act++;
    end
    checks++;
    if (n_act != PL) begin
      fails++;
      $display("FAIL R5/R6 gated pulse width: got %0d expected %0d", n_act, PL);
    end
    iso_n = 1'b1; gate_en = 1'b0; wake_style = 2'b00; step(); step(); step();
    clr_pulse();
    chk("R8 clear after release", pme_oe, 1'b0);

    // R10: event beats clear.
    pwr_evt = 1'b1; evt_clr = 1'b1; step(); pwr_evt = 1'b0; evt_clr = 1'b0;
    chk("R10 event wins", pme_oe, 1'b1);
    chk("R10 wake on", wake_out, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule